// File: doc/BRIEF.md
# Fixed-Point Chaotic Carrier Source with Antipodal Keying

This block produces a chaotic waveform from a four-state, piecewise-linear oscillator of the Chua family. All signals are 14-bit two's complement values with 8 fractional bits. Every enabled clock advances the oscillator by one forward-Euler step with step size 2^-10. That step size is realised as a plain alignment of each rate onto an accumulator that holds 10 extra fractional bits. The constant gains use only shifts and adders: ×0.5, ×1.5 and ×10.

A weighted sum of the four rounded states plus the nonlinearity gives one chaotic sample. A single data bit keys the polarity of that sample: it passes the sample or its arithmetic negation to the output. The block therefore acts as the modulator of a chaotic antipodal shift-keying transmitter. The four states are also brought out so that they can be observed.

Top module: `acsk_chaos_mod`

## Requirements
- R1: While `rst` is high at a rising edge, the states load p1 = 26 (0.1 in Q6.8) and p2 = p3 = p4 = 0. These values are visible on the state ports from the next cycle.
- R2: When `en` is low at a rising edge, all four states keep their values.
- R3: When `en` is high at a rising edge, each state accumulator (Q6.18, 24 bits) gets its rate added, where the rate is a Q.8 value aligned at the accumulator LSB (h = 2^-10). The sum saturates at the 24-bit limits. Each state port shows its accumulator shifted right by 10 with round-half-up, saturated to 14 bits.
- R4: With diff = p1 − p3, the nonlinearity g is 3·(diff − 256) when diff > 256, and 0 otherwise. The result saturates to 14 bits.
- R5: The rates are: p1 gets g − p2; p2 gets p1 + (p2 >>> 1); p3 gets 8·e + 2·e with e = g − p4; p4 gets p3 + (p3 >>> 1). Each rate saturates to 18 bits.
- R6: The chaotic sample is the sum of (K·p) >>> 8 for the Q.8 coefficients K1 = −673, K2 = −155, K3 = 150 and K4 = 199, plus g. The sum saturates to 14 bits.
- R7: `data_bit` = 0 puts the sample on `tx_sample` unchanged. `data_bit` = 1 puts its two's complement negation there, and −8192 maps to +8191.
- R8: A change of `data_bit` reaches `tx_sample` in the same cycle and has no effect on the states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one Euler step at this edge |
| data_bit | input | 1 | Polarity key: 0 direct, 1 negated |
| tx_sample | output | 14 | Keyed chaotic sample, Q6.8 |
| st_p1 | output | 14 | State p1, Q6.8 |
| st_p2 | output | 14 | State p2, Q6.8 |
| st_p3 | output | 14 | State p3, Q6.8 |
| st_p4 | output | 14 | State p4, Q6.8 |

## Verification
An Euler step and a polarity change can land in the same cycle. The output then has to show the new states with the new polarity, with no mix of old and new. The bench randomises `en` and `data_bit` independently on every cycle, so the two events often coincide, and it compares `tx_sample` and the states against a bench model that applies both. Separate directed stretches toggle `data_bit` with `en` low to show that the states stay untouched while the output sign follows the key.

// File: rtl/acsk_pkg.sv
package acsk_pkg;

    typedef enum logic {
        POL_DIRECT = 1'b0,
        POL_INVERT = 1'b1
    } pol_e;

    localparam int N_STATES = 4;

    // Clamp a signed integer into the range of a w-bit two's complement word.
    function automatic int sat_int(input int x, input int w);
        int hi;
        int lo;
        hi = (1 <<< (w - 1)) - 1;
        lo = -(1 <<< (w - 1));
        if (x > hi)      return hi;
        else if (x < lo) return lo;
        else             return x;
    endfunction

    // Arithmetic right shift with round-half-up.
    function automatic int round_shr(input int x, input int sh);
        return (x + (1 <<< (sh - 1))) >>> sh;
    endfunction

endpackage

// File: rtl/chua_nonlin.sv
module chua_nonlin #(
    parameter int W    = 14,
    parameter int FRAC = 8
) (
    input  logic signed [W-1:0] p1,
    input  logic signed [W-1:0] p3,
    output logic signed [W-1:0] g
);
    import acsk_pkg::*;

    localparam int ONE = 1 <<< FRAC;

    always_comb begin
        int diff;
        int excess;
        diff   = int'(p1) - int'(p3);
        excess = diff - ONE;
        if (diff > ONE) g = W'(sat_int((excess <<< 1) + excess, W));
        else            g = '0;
    end

endmodule

// File: rtl/chua_rates.sv
module chua_rates #(
    parameter int W  = 14,
    parameter int DW = 18
) (
    input  logic signed [W-1:0]  p1,
    input  logic signed [W-1:0]  p2,
    input  logic signed [W-1:0]  p3,
    input  logic signed [W-1:0]  p4,
    input  logic signed [W-1:0]  g,
    output logic signed [DW-1:0] d1,
    output logic signed [DW-1:0] d2,
    output logic signed [DW-1:0] d3,
    output logic signed [DW-1:0] d4
);
    import acsk_pkg::*;

    always_comb begin
        int e;
        e  = int'(g) - int'(p4);
        d1 = DW'(sat_int(int'(g) - int'(p2), DW));
        d2 = DW'(sat_int(int'(p1) + (int'(p2) >>> 1), DW));
        d3 = DW'(sat_int((e <<< 3) + (e <<< 1), DW));
        d4 = DW'(sat_int(int'(p3) + (int'(p3) >>> 1), DW));
    end

endmodule

// File: rtl/euler_integ.sv
module euler_integ #(
    parameter int W      = 14,
    parameter int HSHIFT = 10,
    parameter int DW     = 18,
    parameter int INIT   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] rate,
    output logic signed [W-1:0]  q
);
    import acsk_pkg::*;

    localparam int AW = W + HSHIFT;

    logic signed [AW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst)     acc <= AW'(INIT <<< HSHIFT);
        else if (en) acc <= AW'(sat_int(int'(acc) + int'(rate), AW));
    end

    always_comb q = W'(sat_int(round_shr(int'(acc), HSHIFT), W));

endmodule

// File: rtl/chaos_mixer.sv
module chaos_mixer #(
    parameter int W    = 14,
    parameter int FRAC = 8,
    parameter int K1   = -673,
    parameter int K2   = -155,
    parameter int K3   = 150,
    parameter int K4   = 199
) (
    input  logic signed [W-1:0] p1,
    input  logic signed [W-1:0] p2,
    input  logic signed [W-1:0] p3,
    input  logic signed [W-1:0] p4,
    input  logic signed [W-1:0] g,
    output logic signed [W-1:0] r
);
    import acsk_pkg::*;

    always_comb begin
        int acc;
        acc = ((K1 * int'(p1)) >>> FRAC)
            + ((K2 * int'(p2)) >>> FRAC)
            + ((K3 * int'(p3)) >>> FRAC)
            + ((K4 * int'(p4)) >>> FRAC)
            + int'(g);
        r = W'(sat_int(acc, W));
    end

endmodule

// File: rtl/acsk_chaos_mod.sv
module acsk_chaos_mod #(
    parameter int W       = 14,
    parameter int FRAC    = 8,
    parameter int HSHIFT  = 10,
    parameter int P1_INIT = 26,
    parameter int K1      = -673,
    parameter int K2      = -155,
    parameter int K3      = 150,
    parameter int K4      = 199
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         data_bit,
    output logic [W-1:0] tx_sample,
    output logic [W-1:0] st_p1,
    output logic [W-1:0] st_p2,
    output logic [W-1:0] st_p3,
    output logic [W-1:0] st_p4
);
    import acsk_pkg::*;

    localparam int DW = W + 4;
    localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

    logic signed [W-1:0]  p_q  [N_STATES];
    logic signed [DW-1:0] rate [N_STATES];
    logic signed [W-1:0]  g_val;
    logic signed [W-1:0]  r_val;
    logic signed [W-1:0]  r_neg;
    pol_e                 pol;

    chua_nonlin #(.W(W), .FRAC(FRAC)) u_nonlin (
        .p1(p_q[0]), .p3(p_q[2]), .g(g_val)
    );

    chua_rates #(.W(W), .DW(DW)) u_rates (
        .p1(p_q[0]), .p2(p_q[1]), .p3(p_q[2]), .p4(p_q[3]), .g(g_val),
        .d1(rate[0]), .d2(rate[1]), .d3(rate[2]), .d4(rate[3])
    );

    for (genvar i = 0; i < N_STATES; i++) begin : g_integ
        euler_integ #(
            .W(W), .HSHIFT(HSHIFT), .DW(DW),
            .INIT((i == 0) ? P1_INIT : 0)
        ) u_integ (
            .clk(clk), .rst(rst), .en(en), .rate(rate[i]), .q(p_q[i])
        );
    end

    chaos_mixer #(
        .W(W), .FRAC(FRAC), .K1(K1), .K2(K2), .K3(K3), .K4(K4)
    ) u_mixer (
        .p1(p_q[0]), .p2(p_q[1]), .p3(p_q[2]), .p4(p_q[3]), .g(g_val),
        .r(r_val)
    );

    // Antipodal key: invert-plus-one, with the single overflow case clamped.
    always_comb begin
        pol   = pol_e'(data_bit);
        r_neg = (r_val == S_MIN) ? S_MAX : (~r_val + W'(1));
        tx_sample = (pol == POL_INVERT) ? r_neg : r_val;
    end

    assign st_p1 = p_q[0];
    assign st_p2 = p_q[1];
    assign st_p3 = p_q[2];
    assign st_p4 = p_q[3];

endmodule

// File: rtl/acsk_chaos_mod_chk.sv
module acsk_chaos_mod_chk #(
    parameter int W       = 14,
    parameter int HSHIFT  = 10,
    parameter int P1_INIT = 26
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                data_bit,
    input logic [W-1:0]        tx_sample,
    input logic [W-1:0]        st_p1,
    input logic [W-1:0]        st_p2,
    input logic [W-1:0]        st_p3,
    input logic [W-1:0]        st_p4,
    input logic signed [W-1:0] g_val
);
    localparam int DW       = W + 4;
    localparam int STEP_MAX = (1 <<< (DW - 1 - HSHIFT)) + 1;
    localparam int S_MAX    = (1 <<< (W - 1)) - 1;
    localparam int S_MIN    = -(1 <<< (W - 1));

    // R1: reset values appear after a reset edge
    a_r1_reset_init: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int'($signed(st_p1)) == P1_INIT && st_p2 == '0
                        && st_p3 == '0 && st_p4 == '0));

    // R2: no enable, no state change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(st_p1) && $stable(st_p2) && $stable(st_p3) && $stable(st_p4)));

    // R3: one step moves p1 by at most the largest rate scaled by h
    a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
        en |=> ((int'($signed(st_p1)) - int'($signed($past(st_p1))) <= STEP_MAX) &&
                (int'($signed($past(st_p1))) - int'($signed(st_p1)) <= STEP_MAX)));

    // R4: the nonlinearity is never negative
    a_r4_g_nonneg: assert property (@(posedge clk) disable iff (rst)
        !g_val[W-1]);

    // R7, R8: with the states frozen, a key flip mirrors the output
    a_r7_flip: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && data_bit != $past(data_bit)
         && int'($signed($past(tx_sample))) != S_MIN
         && int'($signed($past(tx_sample))) != S_MAX)
        |-> int'($signed(tx_sample)) == -int'($signed($past(tx_sample))));

endmodule

bind acsk_chaos_mod acsk_chaos_mod_chk #(
    .W(W), .HSHIFT(HSHIFT), .P1_INIT(P1_INIT)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .data_bit(data_bit),
    .tx_sample(tx_sample), .st_p1(st_p1), .st_p2(st_p2),
    .st_p3(st_p3), .st_p4(st_p4), .g_val(g_val)
);

// File: tb/acsk_chaos_mod_bench.sv
module acsk_chaos_mod_bench;

    localparam int W   = 14;
    localparam int AW  = 24;
    localparam int DW  = 18;
    localparam int SH  = 10;
    localparam int N_RAND = 30000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic data_bit = 1'b0;
    logic [W-1:0] tx_sample, st_p1, st_p2, st_p3, st_p4;

    int n_checks = 0;
    int n_errors = 0;
    int m_acc [4];
    bit done = 1'b0;

    always #10 clk = ~clk;

    acsk_chaos_mod u_acsk_chaos_mod (
        .clk(clk), .rst(rst), .en(en), .data_bit(data_bit),
        .tx_sample(tx_sample), .st_p1(st_p1), .st_p2(st_p2),
        .st_p3(st_p3), .st_p4(st_p4)
    );

    function automatic int clampw(input int x, input int w);
        int hi = (1 <<< (w - 1)) - 1;
        int lo = -(1 <<< (w - 1));
        return (x > hi) ? hi : ((x < lo) ? lo : x);
    endfunction

    function automatic int m_state(input int i);
        return clampw((m_acc[i] + 512) >>> SH, W);
    endfunction

    function automatic int m_g();
        int d = m_state(0) - m_state(2);
        return (d > 256) ? clampw(3 * (d - 256), W) : 0;
    endfunction

    function automatic int m_sample();
        int s;
        s = ((-673 * m_state(0)) >>> 8) + ((-155 * m_state(1)) >>> 8)
          + ((150 * m_state(2)) >>> 8) + ((199 * m_state(3)) >>> 8) + m_g();
        return clampw(s, W);
    endfunction

    function automatic int m_tx(input logic key);
        int s = m_sample();
        return key ? clampw(-s, W) : s;
    endfunction

    task automatic m_reset();
        m_acc[0] = 26 <<< SH;
        m_acc[1] = 0;
        m_acc[2] = 0;
        m_acc[3] = 0;
    endtask

    task automatic m_step();
        int p1, p2, p3, p4, g, e;
        int rt [4];
        p1 = m_state(0); p2 = m_state(1); p3 = m_state(2); p4 = m_state(3);
        g  = m_g();
        e  = g - p4;
        rt[0] = clampw(g - p2, DW);
        rt[1] = clampw(p1 + (p2 >>> 1), DW);
        rt[2] = clampw(10 * e, DW);
        rt[3] = clampw(p3 + (p3 >>> 1), DW);
        for (int i = 0; i < 4; i++) m_acc[i] = clampw(m_acc[i] + rt[i], AW);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " p1"}, int'($signed(st_p1)), m_state(0));
        chk({tag, " p2"}, int'($signed(st_p2)), m_state(1));
        chk({tag, " p3"}, int'($signed(st_p3)), m_state(2));
        chk({tag, " p4"}, int'($signed(st_p4)), m_state(3));
        chk({tag, " tx"}, int'($signed(tx_sample)), m_tx(data_bit));
    endtask

    // Drive one cycle: set inputs at the falling edge, check, then model the edge.
    task automatic cycle(input logic e_in, input logic d_in, input string tag);
        @(negedge clk);
        en = e_in;
        data_bit = d_in;
        #1;
        chk_all(tag);
        if (e_in) m_step();
    endtask

    initial begin
        int hold_p1;
        int g_seen;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset values
        chk("R1 p1 init", int'($signed(st_p1)), 26);
        chk("R1 p2 init", int'($signed(st_p2)), 0);
        chk_all("R1");

        // R2: enable low keeps the state
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, "R2 hold");
        chk("R2 p1 held", int'($signed(st_p1)), 26);

        // R3, R5: a first few deterministic steps
        for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, "R3 R5 step");

        // R7, R8: key flips with states frozen
        hold_p1 = int'($signed(st_p1));
        for (int i = 0; i < 6; i++) cycle(1'b0, logic'(i % 2), "R7 R8 key");
        chk("R8 state untouched", int'($signed(st_p1)), hold_p1);

        // R3..R8: random enable and key, both changing in the same cycle
        g_seen = 0;
        for (int i = 0; i < N_RAND; i++) begin
            cycle(($urandom % 8) != 0, logic'($urandom % 2), "R3 R4 R6 R7 rand");
            if (m_g() != 0) g_seen++;
        end
        // R4: the nonlinearity must have engaged during the run
        chk("R4 g active", (g_seen > 0) ? 1 : 0, 1);

        // R1: reset mid-run restores the start values
        @(negedge clk);
        rst = 1'b1;
        en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_reset();
        #1;
        chk_all("R1 rerun");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (N_RAND + 2000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule